// File: doc/BRIEF.md
# Serial Set/Clear Pattern Detector

This block watches a one-bit serial stream, taking one sample on every rising clock edge. It compares the most recent six samples against two fixed six-bit patterns. One pattern is the "set" pattern and the other is the "clear" pattern. A set match raises a registered `detect_o` flag. The flag then holds, whatever the stream does next, until a clear match drops it.

Both patterns are decoded from the same stream, each in its own six-stage history window. The comparison slides by one sample per clock, so occurrences that overlap are all found. Two combinational pulse outputs expose the raw matches for the cycle they occur in. After reset, no match is reported until six fresh samples have been taken.

Top module: `sticky_pattern_detector`

## Requirements
- R1: While `rst_ni` is low, `detect_o`, `set_hit_o` and `clr_hit_o` are all 0.
- R2: `set_hit_o` is 1 exactly when the last six samples, oldest first, are 1,0,1,0,1,1. It is valid from the rising edge that took the newest of those samples until the next edge.
- R3: `clr_hit_o` is 1 exactly when the last six samples, oldest first, are 1,0,0,1,1,0. It uses the same timing as R2, and it is never 1 in the same cycle as `set_hit_o`.
- R4: `detect_o` becomes 1 on the rising edge after a cycle in which `set_hit_o` is 1 and `clr_hit_o` is 0.
- R5: Once `detect_o` is 1, it stays 1 while no clear match occurs, whatever the input.
- R6: `detect_o` becomes 0 on the rising edge after a cycle in which `clr_hit_o` is 1. Clear wins over set. The flag then stays 0 until the next set match.
- R7: Matching slides one sample per clock, so overlapping occurrences of a pattern each produce a hit.
- R8: No hit is reported until six samples have been taken since reset was released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the stream is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Serial data bit |
| detect_o | output | 1 | Sticky detect flag, registered |
| set_hit_o | output | 1 | Set pattern currently in window |
| clr_hit_o | output | 1 | Clear pattern currently in window |

## Verification
The assertions assume that `data_i` holds a defined 0 or 1 at every rising edge. They also assume that reset is released away from a clock edge. The bench changes `data_i` and `rst_ni` only on the falling edge and always drives a constant bit. Random bits are mixed with directed runs of each pattern, with overlapping set occurrences, and with clears issued both while the flag is high and while it is low.

// File: rtl/det_pkg.sv
package det_pkg;
  localparam int unsigned DET_W = 6;
  // oldest sample in MSB
  localparam logic [DET_W-1:0] DET_SET_PAT = 6'b101011;
  localparam logic [DET_W-1:0] DET_CLR_PAT = 6'b100110;
endpackage

// File: rtl/det_fill.sv
module det_fill #(
  parameter int unsigned W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == FULL);

  p_valid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/det_window.sv
module det_window #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] PAT = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic valid_i,
  output logic hit_o
);
  logic [W-1:0] win_q;
  logic [W-1:0] eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= {win_q[W-2:0], data_i};
  end

  // per-stage polarised compare, then W-input AND
  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign eq[i] = PAT[i] ? win_q[i] : ~win_q[i];
  end

  assign hit_o = valid_i & (&eq);

  p_no_early_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
  p_slide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q[W-1:1] == $past(win_q[W-2:0]));
endmodule

// File: rtl/det_latch.sv
module det_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> q_o);
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/sticky_pattern_detector.sv
module sticky_pattern_detector
  import det_pkg::*;
#(
  parameter int unsigned W = DET_W,
  parameter logic [W-1:0] SET_PAT = DET_SET_PAT,
  parameter logic [W-1:0] CLR_PAT = DET_CLR_PAT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic detect_o,
  output logic set_hit_o,
  output logic clr_hit_o
);
  logic valid;

  det_fill #(.W(W)) u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_o(valid)
  );

  det_window #(.W(W), .PAT(SET_PAT)) u_set_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(valid),
    .hit_o  (set_hit_o)
  );

  det_window #(.W(W), .PAT(CLR_PAT)) u_clr_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(valid),
    .hit_o  (clr_hit_o)
  );

  det_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_hit_o),
    .clr_i (clr_hit_o),
    .q_o   (detect_o)
  );

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_hit_o && clr_hit_o));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!detect_o && !set_hit_o && !clr_hit_o));
endmodule

// File: tb/sticky_pattern_detector_tb.sv
module sticky_pattern_detector_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic detect_o, set_hit_o, clr_hit_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [5:0] m_win;
  int         m_cnt;
  logic       m_det;

  always #10ns clk_i = ~clk_i;

  sticky_pattern_detector u_dut (
    .clk_i, .rst_ni, .data_i, .detect_o, .set_hit_o, .clr_hit_o
  );

  function automatic logic f_set(logic [5:0] w, int c);
    return (c >= 6) && (w == 6'b101011);
  endfunction
  function automatic logic f_clr(logic [5:0] w, int c);
    return (c >= 6) && (w == 6'b100110);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 set_hit"}, set_hit_o, f_set(m_win, m_cnt));
    chk({tag, " R3 clr_hit"}, clr_hit_o, f_clr(m_win, m_cnt));
    chk({tag, " R5 detect"}, detect_o, m_det);
  endtask

  // drive at negedge, advance model for the coming edge, check at next negedge
  task automatic step(logic b, string tag);
    logic s, c;
    data_i = b;
    s = f_set(m_win, m_cnt);
    c = f_clr(m_win, m_cnt);
    if (c) m_det = 1'b0;
    else if (s) m_det = 1'b1;
    m_win = {m_win[4:0], b};
    if (m_cnt < 6) m_cnt++;
    @(posedge clk_i);
    @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic send(logic [5:0] p, string tag);
    for (int i = 5; i >= 0; i--) step(p[i], tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_win = '0; m_cnt = 0; m_det = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 detect", detect_o, 1'b0);
    chk("R1 set_hit", set_hit_o, 1'b0);
    chk("R1 clr_hit", clr_hit_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    #(200000 * 20ns);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int unsigned r;
    r = $urandom(32'd4217);
    @(negedge clk_i);
    do_reset();

    // R8: first five samples of a set pattern give no hit
    for (int i = 5; i >= 1; i--) begin
      step(1'(6'b101011 >> i), "fill");
      chk("R8 no early hit", set_hit_o, 1'b0);
    end
    step(1'b1, "fill-last");
    chk("R2 set hit at sixth", set_hit_o, 1'b1);
    step(1'b0, "after-set");
    chk("R4 detect rises", detect_o, 1'b1);

    // R5: hold through noise without clear
    repeat (10) step(1'b0, "hold");
    chk("R5 detect held", detect_o, 1'b1);

    // R6: clear drops, stays low
    send(6'b100110, "clr");
    chk("R3 clr hit", clr_hit_o, 1'b1);
    step(1'b1, "after-clr");
    chk("R6 detect dropped", detect_o, 1'b0);
    repeat (5) step(1'b1, "low-hold");
    chk("R6 stays low", detect_o, 1'b0);

    // R7: overlapping set occurrences 10101101011
    send(6'b101011, "ovl1");
    chk("R7 first occurrence", set_hit_o, 1'b1);
    step(1'b0, "ovl"); step(1'b1, "ovl"); step(1'b0, "ovl");
    step(1'b1, "ovl"); step(1'b1, "ovl");
    chk("R7 overlapping occurrence", set_hit_o, 1'b1);

    // clear then set back to back
    send(6'b100110, "clr2");
    send(6'b101011, "set2");
    step(1'b0, "set2b");
    chk("R4 re-set", detect_o, 1'b1);

    // mid-run reset
    @(negedge clk_i);
    do_reset();

    // random stream with occasional directed patterns
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      if (r[7:0] == 8'd3)      send(6'b101011, "rnd-set");
      else if (r[7:0] == 8'd7) send(6'b100110, "rnd-clr");
      else                     step(r[16], "rnd");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule